// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Sensing

This block is a register-mapped general-purpose I/O controller for up to 32 pins. Each pin can be an input or an output. Outputs are driven from a value register as a data/enable pair for an external tri-state pad. Inputs pass through a two-flop synchroniser. Reading the value register returns a mix: synchronised levels for input pins and the written value for output pins.

Every pin also has its own interrupt sense logic. A pin can sense a high level, a low level, a rising edge, a falling edge or both edges. Detected events collect in a raw status register. An enable mask selects which of them reach the single combined interrupt line. Software acknowledges edge events by writing ones to a clear register. The bus is a simple word-addressed port with address, write enable, write data and combinational read data. Register offsets are byte offsets, and only word-aligned accesses hit a register.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Direction register (offset 0x04) resets to all ones. A bit of 1 makes the pin an input with `pad_oe_o` low. A bit of 0 makes it an output with `pad_oe_o` high, and `pad_out_o` always carries the value register.
- R2: Reading offset 0x00 returns, for each input pin, the pad level two clocks after it changed. For each output pin it returns the last value written to 0x00.
- R3: Mode bit 0 (mode register, offset 0x18) selects level sensing. Polarity bit 1 (offset 0x1C) means active high and 0 means active low. The status bit follows the condition, and a clear write has no effect on it.
- R4: Mode bit 1 selects edge sensing with the both-edges bit clear. Polarity 1 latches on a rising edge and 0 on a falling edge. The opposite edge is ignored. A latched bit stays set until it is cleared.
- R5: Both-edges bit 1 (offset 0x24) in edge mode latches on either transition, whatever the polarity bit holds.
- R6: Writing a 1 to a bit of the clear register (offset 0x14) drops that latched edge event. A 0 leaves it unchanged. An edge detected in the same cycle as the clear wins, and the bit stays set. The clear register reads as zero.
- R7: Offset 0x0C reads the raw status. Offset 0x10 reads status AND enable (enable at offset 0x08). `irq_o` is high exactly when some enabled status bit is set.
- R8: The enable register resets to zero, so `irq_o` is low when reset is released.
- R9: Offset 0x20 reads the constant VERSION (default 3, which marks both-edge support). Writes to it, to status and to the masked pending view are ignored.
- R10: A pad transition shows in the status register on the third rising clock edge after it. That is two synchroniser stages plus one latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | 6 | Byte address of the register |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| irq_o | output | 1 | Combined interrupt |
| pad_in_i | input | NPINS | Asynchronous pad levels |
| pad_out_o | output | NPINS | Pad drive value |
| pad_oe_o | output | NPINS | Pad drive enable, high for output |

## Verification
Register writes take effect on the clock edge that captures them, and read data is combinational. The bench therefore reads back on the falling edge straight after each write. A pad change reaches the value readback two rising edges later and the status register three rising edges later. The bench sets pads on a falling edge and samples after exactly two or three further falling edges. It also checks that the old value still holds one edge earlier. For the clear-versus-edge race, the clear write is timed so that it is captured on the same rising edge that latches the new edge.

// File: rtl/gpio_irq_pkg.sv
// Shared register index encoding for the GPIO interrupt controller.
// Assumes word-aligned byte addresses; the index is address bits [5:2].
package gpio_irq_pkg;
    localparam int ADDR_W = 6;
    localparam int IDX_W  = 4;

    typedef enum logic [IDX_W-1:0] {
        RG_VALUE = 4'd0,
        RG_DIR   = 4'd1,
        RG_IEN   = 4'd2,
        RG_STAT  = 4'd3,
        RG_PEND  = 4'd4,
        RG_CLR   = 4'd5,
        RG_MODE  = 4'd6,
        RG_POL   = 4'd7,
        RG_VER   = 4'd8,
        RG_BOTH  = 4'd9
    } reg_idx_e;
endpackage

// File: rtl/gpio_sync.sv
// Multi-stage synchroniser for asynchronous pad inputs.
// Assumes each bit is independent; the output lags the input by STAGES clocks.
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // Shift the pad level one stage further per clock.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stage_q[s] <= '0;
            else if (s == 0)
                stage_q[s] <= async_i;
            else
                stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_detect.sv
// Per-pin interrupt sensing: level (follows the condition) or edge (latched
// until cleared), with an optional both-edges override of the polarity.
// Assumes smp_i is already synchronous to clk.
module gpio_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] smp_i,
    input  logic [W-1:0] mode_i,   // 1 = edge, 0 = level
    input  logic [W-1:0] pol_i,    // 1 = high/rising, 0 = low/falling
    input  logic [W-1:0] both_i,   // 1 = either edge (edge mode only)
    input  logic [W-1:0] clr_i,    // one-cycle clear strobe per pin
    output logic [W-1:0] pend_o
);
    logic [W-1:0] prev_q;
    logic [W-1:0] pend_q;
    logic [W-1:0] pend_d;
    logic [W-1:0] hit;

    // Remember the synchronised level from one clock earlier.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= smp_i;
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic rise, fall, lvl;
        assign rise      = smp_i[i] & ~prev_q[i];
        assign fall      = ~smp_i[i] & prev_q[i];
        assign hit[i]    = mode_i[i] & (both_i[i] ? (rise | fall)
                                                  : (pol_i[i] ? rise : fall));
        assign lvl       = ~mode_i[i] & (smp_i[i] == pol_i[i]);
        assign pend_d[i] = lvl | (mode_i[i] & ((pend_q[i] & ~clr_i[i]) | hit[i]));
    end

    // Register the raw event state of every pin.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;

    // R5: any transition on a both-edge pin is latched on the next clock.
    a_r5_both_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (|((smp_i ^ prev_q) & mode_i & both_i)) |=>
        ((pend_q & $past((smp_i ^ prev_q) & mode_i & both_i)) ==
         $past((smp_i ^ prev_q) & mode_i & both_i)));

    // R6: a clear with no competing edge drops the latched edge bit.
    a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & mode_i & ~hit)) |=>
        ((pend_q & $past(clr_i & mode_i & ~hit)) == '0));

    // R4: a latched edge bit without a clear stays set.
    a_r4_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend_q & mode_i & ~clr_i)) |=>
        ((pend_q & $past(pend_q & mode_i & ~clr_i)) ==
         $past(pend_q & mode_i & ~clr_i)));
endmodule

// File: rtl/gpio_regs.sv
// Register file and read multiplexer of the GPIO controller.
// Assumes a word-aligned byte address; misaligned accesses hit nothing.
module gpio_regs
    import gpio_irq_pkg::*;
#(
    parameter int          W       = 32,
    parameter logic [31:0] VERSION = 32'd3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [31:0]       wdata_i,
    input  logic [W-1:0]      smp_i,
    input  logic [W-1:0]      pend_i,
    output logic [W-1:0]      dir_o,
    output logic [W-1:0]      out_o,
    output logic [W-1:0]      ien_o,
    output logic [W-1:0]      mode_o,
    output logic [W-1:0]      pol_o,
    output logic [W-1:0]      both_o,
    output logic [W-1:0]      clr_o,
    output logic [31:0]       rdata_o
);
    logic     aligned;
    reg_idx_e idx;
    logic     wr;

    assign aligned = (addr_i[1:0] == 2'b00);
    assign idx     = reg_idx_e'(addr_i[ADDR_W-1:2]);
    assign wr      = we_i & aligned;

    // Update the writable configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_o  <= '1;
            out_o  <= '0;
            ien_o  <= '0;
            mode_o <= '0;
            pol_o  <= '0;
            both_o <= '0;
        end else if (wr) begin
            case (idx)
                RG_VALUE: out_o  <= wdata_i[W-1:0];
                RG_DIR:   dir_o  <= wdata_i[W-1:0];
                RG_IEN:   ien_o  <= wdata_i[W-1:0];
                RG_MODE:  mode_o <= wdata_i[W-1:0];
                RG_POL:   pol_o  <= wdata_i[W-1:0];
                RG_BOTH:  both_o <= wdata_i[W-1:0];
                default:  ;
            endcase
        end
    end

    // Produce the one-cycle clear strobe.
    always_comb begin
        clr_o = '0;
        if (wr && idx == RG_CLR) clr_o = wdata_i[W-1:0];
    end

    // Select the read data for the addressed register.
    always_comb begin
        rdata_o = '0;
        if (aligned) begin
            case (idx)
                RG_VALUE: rdata_o = 32'((dir_o & smp_i) | (~dir_o & out_o));
                RG_DIR:   rdata_o = 32'(dir_o);
                RG_IEN:   rdata_o = 32'(ien_o);
                RG_STAT:  rdata_o = 32'(pend_i);
                RG_PEND:  rdata_o = 32'(pend_i & ien_o);
                RG_MODE:  rdata_o = 32'(mode_o);
                RG_POL:   rdata_o = 32'(pol_o);
                RG_VER:   rdata_o = VERSION;
                RG_BOTH:  rdata_o = 32'(both_o);
                default:  rdata_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
// Top of the GPIO controller with per-pin interrupt sensing.
// Assumes NPINS <= 32 and asynchronous pad inputs; reset is synchronous.
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int          NPINS   = 32,
    parameter int          STAGES  = 2,
    parameter logic [31:0] VERSION = 32'd3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    output logic              irq_o,
    input  logic [NPINS-1:0]  pad_in_i,
    output logic [NPINS-1:0]  pad_out_o,
    output logic [NPINS-1:0]  pad_oe_o
);
    logic [NPINS-1:0] smp, pend, dir, outv, ien, mode, pol, both, clr;

    gpio_sync #(.W(NPINS), .STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pad_in_i), .sync_o(smp));

    gpio_detect #(.W(NPINS)) u_detect (
        .clk(clk), .rst_n(rst_n), .smp_i(smp), .mode_i(mode), .pol_i(pol),
        .both_i(both), .clr_i(clr), .pend_o(pend));

    gpio_regs #(.W(NPINS), .VERSION(VERSION)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .we_i(we_i),
        .wdata_i(wdata_i), .smp_i(smp), .pend_i(pend), .dir_o(dir),
        .out_o(outv), .ien_o(ien), .mode_o(mode), .pol_o(pol),
        .both_o(both), .clr_o(clr), .rdata_o(rdata_o));

    // Drive the pads and combine the enabled events.
    assign pad_out_o = outv;
    assign pad_oe_o  = ~dir;
    assign irq_o     = |(pend & ien);

    // R1: a direction write sets the drive enables on the next clock.
    a_r1_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == {RG_DIR, 2'b00}) |=>
        (pad_oe_o == ~$past(wdata_i[NPINS-1:0])));

    // R1: a value write appears on the pad drive on the next clock.
    a_r1_value_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == {RG_VALUE, 2'b00}) |=>
        (pad_out_o == $past(wdata_i[NPINS-1:0])));

    // R8: the interrupt is low as reset is released.
    a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq_o);
endmodule

// File: tb/gpio_irq_ctrl_bench.sv
module gpio_irq_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic [31:0] pads = '1;
    logic [31:0] pad_out, pad_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    gpio_irq_ctrl u_gpio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
        .rdata_o(rdata), .irq_o(irq), .pad_in_i(pads),
        .pad_out_o(pad_out), .pad_oe_o(pad_oe));

    always #(CLK_PERIOD/2) clk = ~clk;

    localparam logic [5:0] A_VAL = 6'h00, A_DIR = 6'h04, A_IEN = 6'h08,
        A_STAT = 6'h0C, A_PEND = 6'h10, A_CLR = 6'h14, A_MODE = 6'h18,
        A_POL = 6'h1C, A_VER = 6'h20, A_BOTH = 6'h24;

    typedef struct packed {
        logic [5:0]  a;
        logic [31:0] w;
        logic [31:0] e;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{A_DIR,  32'h0000_FFFF, 32'h0000_FFFF},   // R1
        '{A_VAL,  32'hA5A5_0000, 32'hA5A5_FFFF},   // R2 mixed pins
        '{A_IEN,  32'h0000_0000, 32'h0000_0000},   // R7
        '{A_MODE, 32'h0000_00F0, 32'h0000_00F0},   // R3/R4
        '{A_POL,  32'h0000_0055, 32'h0000_0055},   // R3/R4
        '{A_BOTH, 32'h0000_0080, 32'h0000_0080},   // R5
        '{A_VER,  32'h0000_0000, 32'h0000_0003},   // R9 write ignored
        '{A_CLR,  32'h0000_FFFF, 32'h0000_0000}    // R6 reads zero
    };

    task automatic chk(input string tag, input logic [31:0] got,
                       input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    // Called just after a falling edge; returns just after the next one.
    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wait_n(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        logic [31:0] r;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R8 irq after reset", {31'd0, irq}, 32'd0);
        chk("R1 oe after reset", pad_oe, 32'h0);
        chk("R1 out after reset", pad_out, 32'h0);
        rd(A_IEN, r); chk("R8 enable reset", r, 32'h0);
        rd(A_DIR, r); chk("R1 dir reset", r, 32'hFFFF_FFFF);
        rd(A_VER, r); chk("R9 version", r, 32'd3);
        wait_n(6);

        for (int i = 0; i < NV; i++) begin
            wr(VECS[i].a, VECS[i].w);
            rd(VECS[i].a, r);
            chk($sformatf("R1/R2/R9 vector %0d", i), r, VECS[i].e);
        end
        chk("R1 oe after dir write", pad_oe, 32'hFFFF_0000);
        wait_n(4);

        // Level sensing: bits 0,2 active high with pads high.
        rd(A_STAT, r); chk("R3 level active high", r, 32'h0000_0005);
        wr(A_CLR, 32'h1);
        rd(A_STAT, r); chk("R3 clear ignored in level", r, 32'h0000_0005);
        pads[0] = 1'b0;
        wait_n(2);
        rd(A_STAT, r); chk("R10 not yet after two edges", r, 32'h0000_0005);
        wait_n(1);
        rd(A_STAT, r); chk("R10 level drop on third edge", r, 32'h0000_0004);
        pads[1] = 1'b0;
        wait_n(3);
        rd(A_STAT, r); chk("R3 active low", r, 32'h0000_0006);

        // Edge sensing on bit4 (rising) and bit5 (falling).
        pads[4] = 1'b0;
        wait_n(4);
        rd(A_STAT, r); chk("R4 falling ignored on rising pin", r, 32'h0000_0006);
        pads[4] = 1'b1;
        wait_n(3);
        rd(A_STAT, r); chk("R4 rising latched", r, 32'h0000_0016);
        wait_n(5);
        rd(A_STAT, r); chk("R4 latch holds", r, 32'h0000_0016);
        pads[5] = 1'b0;
        wait_n(3);
        rd(A_STAT, r); chk("R4 falling latched", r, 32'h0000_0036);

        // Clear and both-edge behaviour.
        wr(A_CLR, 32'h10);
        rd(A_STAT, r); chk("R6 clear one bit", r, 32'h0000_0026);
        pads[7] = 1'b0;
        wait_n(3);
        rd(A_STAT, r); chk("R5 both-edge falling", r, 32'h0000_00A6);
        wr(A_CLR, 32'h80);
        rd(A_STAT, r); chk("R6 clear bit7", r, 32'h0000_0026);
        pads[7] = 1'b1;
        wait_n(2);
        wr(A_CLR, 32'h80);
        rd(A_STAT, r); chk("R6 edge wins over clear / R5 rising", r, 32'h0000_00A6);
        wr(A_CLR, 32'h0);
        rd(A_STAT, r); chk("R6 zero write leaves bits", r, 32'h0000_00A6);
        wr(A_CLR, 32'h80);
        rd(A_STAT, r); chk("R6 clear after race", r, 32'h0000_0026);

        // Enable mask and combined interrupt.
        wr(A_IEN, 32'h20);
        rd(A_PEND, r); chk("R7 masked pending", r, 32'h0000_0020);
        chk("R7 irq high", {31'd0, irq}, 32'd1);
        wr(A_IEN, 32'h100);
        rd(A_PEND, r); chk("R7 masked pending none", r, 32'h0);
        chk("R7 irq low", {31'd0, irq}, 32'd0);
        wr(A_PEND, 32'hFFFF_FFFF);
        wr(A_STAT, 32'h0);
        rd(A_STAT, r); chk("R9 status write ignored", r, 32'h0000_0026);
        wr(A_IEN, 32'h0);

        // Value readback with input latency.
        rd(A_VAL, r); chk("R2 value mixed", r, 32'hA5A5_FFDC);
        pads[15:8] = 8'h00;
        wait_n(1);
        rd(A_VAL, r); chk("R2 not yet after one edge", r, 32'hA5A5_FFDC);
        wait_n(1);
        rd(A_VAL, r); chk("R2 input after two edges", r, 32'hA5A5_00DC);

        // Direction flip and output drive.
        wr(A_DIR, 32'hFFFF_0000);
        chk("R1 oe follows dir", pad_oe, 32'h0000_FFFF);
        chk("R1 out holds value", pad_out, 32'hA5A5_0000);
        wr(A_VAL, 32'h1234_5678);
        chk("R1 out new value", pad_out, 32'h1234_5678);
        rd(A_VAL, r); chk("R2 outputs low half", r, 32'hFFFF_5678);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule